// File: doc/BRIEF.md
# Buffered Up-count PWM Generator

This block produces one pulse-width-modulated output from a 16-bit up counter. A programmable prescaler divides the input clock by (prescale + 1) to form the counting tick; the counter climbs from 0 to the active period value and then starts over at 0, or, in one-shot mode, stops on the period value and drops its own run bit. The output is high while the counter is below the active compare value, optionally inverted, and gated by an output-enable bit that is also presented as a pin so the pad can be put in the high-impedance state.

Software writes period and compare values into staging registers. These move into the active registers, which can be read back separately, only when a period completes, so a waveform change never tears a period in two. Four sticky flags (period point, compare-up point, counter at all-ones, trigger issued) are cleared by writing 1. Two of them can raise the interrupt, and a selectable event source produces a one-cycle trigger pulse for a neighbouring converter or DMA engine.

Register port: `addr` selects a word, writes take effect on the clock edge where `wr_en` is high, and `rdata` is a combinational read of the selected word. Word map: 0 control, 1 staged period, 2 staged compare, 3 active period (read only), 4 active compare (read only), 5 counter (read only), 6 flags (write 1 to clear), 7 counter-clear command. Control word bits: 0 run, 1 one-shot, 2 invert, 3 output enable, 6:4 trigger source, 7 trigger enable, 8 period interrupt enable, 9 compare interrupt enable, 23:16 prescale. Flag word bits: 0 period, 1 compare-up, 2 all-ones, 3 trigger.

Top module: `pwm_upcount_gen`

## Requirements
- R1: The counter advances once every (prescale + 1) clock cycles while running; prescale 0 advances it on every clock.
- R2: In auto-reload mode (control bit 1 = 0) the counter steps 0, 1, ... up to the active period and then returns to 0, so one period lasts (period + 1) ticks.
- R3: Values written to words 1 and 2 are copied to the active period and compare (words 3 and 4) only on the tick that completes a period; before that the active words keep their old values.
- R4: Flag bit 0 is set on the tick at which the counter stands on the active period and stays set until a write of 1 to that bit of word 6.
- R5: Flag bit 1 is set on the tick at which the counter stands on the active compare value, is cleared by writing 1, and is never set while active compare equals active period.
- R6: In one-shot mode (control bit 1 = 1) the counter holds the period value at the end of the period and control bit 0 reads back 0.
- R7: With control bit 0 = 0 the counter and prescaler do not advance.
- R8: Writing word 7 with bit 0 = 1 sets the counter to 0 on that edge; word 7 always reads 0.
- R9: With output enabled, `pwm_o` is 1 while counter < active compare and 0 otherwise, and control bit 2 = 1 inverts it.
- R10: With control bit 3 = 0, `pwm_oe` is 0 and `pwm_o` is held at 0.
- R11: Flag bit 2 is set when the counter ticks while at 0xFFFF and is cleared only by writing 1.
- R12: With control bit 7 = 1, `trig_o` pulses for one cycle per selected event: source 001 the period point, 011 the compare-up point, 101 either; every other code, or bit 7 = 0, gives no pulse.
- R13: Flag bit 3 is set whenever a trigger pulse is issued and is cleared by writing 1.
- R14: `irq_o` is high while (flag 0 and control bit 8) or (flag 1 and control bit 9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word select |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for the selected word |
| pwm_o | output | 1 | PWM waveform |
| pwm_oe | output | 1 | Output-pad enable; 0 means high impedance |
| irq_o | output | 1 | Interrupt request |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
A register write lands on the edge it is sampled at, and a run bit set there first ticks the counter on the following edge, so with prescale 0 the counter value read after k further edges is predictable exactly. Flags and the trigger pulse are registered from the counter value present at a tick, so they become visible right after the edge that moves the counter off the period or compare point, while `pwm_o`, `pwm_oe` and `irq_o` follow their state with no extra register. The bench drives inputs just after a rising edge, advances by whole edges and reads a fraction of a nanosecond later, and where phase is awkward it counts trigger pulses over a window of exactly four whole periods instead of pinning each one.

// File: rtl/pwm_upcount_gen.sv
module pwm_upcount_gen #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        pwm_o,
  output logic        pwm_oe,
  output logic        irq_o,
  output logic        trig_o
);

  localparam int PSC_LSB = 16;

  logic             run, one_shot, inv, oe_en, trig_en, ie_per, ie_cmp;
  logic [2:0]       trig_sel;
  logic [PSC_W-1:0] psc, psc_cnt;
  logic [CNT_W-1:0] cnt, per_sh, cmp_sh, per_act, cmp_act;
  logic             f_per, f_cmp, f_max, f_trg;

  logic wr_ctrl, wr_per, wr_cmp, wr_flag, clr_cmd;
  logic tick, at_per, ev_cmp, ev_max, trig_hit, trig_fire;

  assign wr_ctrl = wr_en && addr == 3'd0;
  assign wr_per  = wr_en && addr == 3'd1;
  assign wr_cmp  = wr_en && addr == 3'd2;
  assign wr_flag = wr_en && addr == 3'd6;
  assign clr_cmd = wr_en && addr == 3'd7 && wdata[0];

  assign tick   = run && (psc_cnt >= psc);
  assign at_per = tick && (cnt >= per_act);
  assign ev_cmp = tick && (cnt == cmp_act) && (cmp_act != per_act);
  assign ev_max = tick && (&cnt);

  always_comb begin
    case (trig_sel)
      3'b001:  trig_hit = at_per;
      3'b011:  trig_hit = ev_cmp;
      3'b101:  trig_hit = at_per | ev_cmp;
      default: trig_hit = 1'b0;
    endcase
  end
  assign trig_fire = trig_en && trig_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; one_shot <= 1'b0; inv <= 1'b0; oe_en <= 1'b0;
      trig_sel <= '0; trig_en <= 1'b0; ie_per <= 1'b0; ie_cmp <= 1'b0;
      psc <= '0;
    end else begin
      if (wr_ctrl) begin
        run      <= wdata[0];
        one_shot <= wdata[1];
        inv      <= wdata[2];
        oe_en    <= wdata[3];
        trig_sel <= wdata[6:4];
        trig_en  <= wdata[7];
        ie_per   <= wdata[8];
        ie_cmp   <= wdata[9];
        psc      <= wdata[PSC_LSB +: PSC_W];
      end
      if (at_per && one_shot) run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh <= '0;
      cmp_sh <= '0;
    end else begin
      if (wr_per) per_sh <= wdata[CNT_W-1:0];
      if (wr_cmp) cmp_sh <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_cnt <= '0;
    else if (!run || clr_cmd || tick) psc_cnt <= '0;
    else psc_cnt <= psc_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr_cmd) cnt <= '0;
    else if (at_per) cnt <= one_shot ? cnt : '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act <= '0;
      cmp_act <= '0;
    end else if (at_per) begin
      per_act <= per_sh;
      cmp_act <= cmp_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_per <= 1'b0; f_cmp <= 1'b0; f_max <= 1'b0; f_trg <= 1'b0;
      trig_o <= 1'b0;
    end else begin
      f_per  <= (f_per & ~(wr_flag & wdata[0])) | at_per;
      f_cmp  <= (f_cmp & ~(wr_flag & wdata[1])) | ev_cmp;
      f_max  <= (f_max & ~(wr_flag & wdata[2])) | ev_max;
      f_trg  <= (f_trg & ~(wr_flag & wdata[3])) | trig_fire;
      trig_o <= trig_fire;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: begin
        rdata[0]   = run;
        rdata[1]   = one_shot;
        rdata[2]   = inv;
        rdata[3]   = oe_en;
        rdata[6:4] = trig_sel;
        rdata[7]   = trig_en;
        rdata[8]   = ie_per;
        rdata[9]   = ie_cmp;
        rdata[PSC_LSB +: PSC_W] = psc;
      end
      3'd1: rdata[CNT_W-1:0] = per_sh;
      3'd2: rdata[CNT_W-1:0] = cmp_sh;
      3'd3: rdata[CNT_W-1:0] = per_act;
      3'd4: rdata[CNT_W-1:0] = cmp_act;
      3'd5: rdata[CNT_W-1:0] = cnt;
      3'd6: rdata[3:0] = {f_trg, f_max, f_cmp, f_per};
      default: rdata = '0;
    endcase
  end

  assign pwm_oe = oe_en;
  assign pwm_o  = oe_en & ((cnt < cmp_act) ^ inv);
  assign irq_o  = (f_per & ie_per) | (f_cmp & ie_cmp);

  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:PSC_LSB+PSC_W], wdata[15:10]};

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3
  buf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != $past(per_act) || cmp_act != $past(cmp_act)) |-> $past(tick));

  // R5
  cmp_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_cmp) |-> $past(cmp_act != per_act));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && one_shot && cnt >= per_act && !wr_ctrl && !clr_cmd) |=> (!run && $stable(cnt)));

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 3'd7 && wdata[0]) |-> cnt == '0);

  // R13
  trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> f_trg);

endmodule

// File: tb/pwm_upcount_gen_tb.sv
`timescale 1ns/10ps
module pwm_upcount_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic pwm_o, pwm_oe, irq_o, trig_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [31:0] RUN = 32'h1, ONE = 32'h2, INV = 32'h4, OE = 32'h8,
                          TEN = 32'h80, IEP = 32'h100;

  always #4 clk = ~clk;

  pwm_upcount_gen dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o), .pwm_oe(pwm_oe),
    .irq_o(irq_o), .trig_o(trig_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #0.05;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R7 reset ctrl", v, 0);
    rd(3'd5, v); chk("R2 reset counter", v, 0);
    rd(3'd6, v); chk("R4 reset flags", v, 0);
    chk("R10 reset oe", pwm_oe, 0);
    chk("R14 reset irq", irq_o, 0);
    chk("R12 reset trig", trig_o, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] v;
    wr(3'd1, 3); wr(3'd2, 1);
    rd(3'd1, v); chk("R3 staged period readback", v, 3);
    rd(3'd3, v); chk("R3 active period before load", v, 0);
    rd(3'd4, v); chk("R3 active compare before load", v, 0);
  endtask

  task automatic t_count();
    logic [31:0] v, h;
    wr(3'd0, RUN | OE);
    step(1);
    rd(3'd3, v); chk("R3 active period loaded", v, 3);
    rd(3'd4, v); chk("R3 active compare loaded", v, 1);
    rd(3'd5, v); chk("R2 count 0", v, 0);
    chk("R9 pwm high below compare", pwm_o, 1);
    step(1); rd(3'd5, v); chk("R2 count 1", v, 1);
    chk("R9 pwm low at compare", pwm_o, 0);
    step(1); rd(3'd5, v); chk("R2 count 2", v, 2);
    step(1); rd(3'd5, v); chk("R2 count 3", v, 3);
    step(1); rd(3'd5, v); chk("R2 wrap to 0", v, 0);
    wr(3'd0, OE);
    rd(3'd5, h);
    step(3);
    rd(3'd5, v); chk("R7 stopped counter holds", v, h);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    wr(3'd6, 32'hF);
    rd(3'd6, v); chk("R4 flags cleared", v, 0);
    wr(3'd0, RUN | OE);
    step(1); rd(3'd6, v); chk("R5 compare flag set", v, 32'h2);
    step(2); rd(3'd6, v); chk("R4 period flag set", v, 32'h3);
    wr(3'd6, 32'h2);
    rd(3'd6, v); chk("R5 compare flag w1c", v, 32'h1);
    wr(3'd6, 32'h1);
    rd(3'd6, v); chk("R4 period flag w1c", v & 32'h1, 0);
  endtask

  task automatic t_suppress();
    logic [31:0] v;
    wr(3'd2, 3);
    step(8);
    rd(3'd4, v); chk("R3 compare reloaded", v, 3);
    wr(3'd6, 32'hF);
    step(12);
    rd(3'd6, v); chk("R5 compare flag suppressed when equal to period", v & 32'h3, 32'h1);
    wr(3'd2, 1);
    step(8);
  endtask

  task automatic count_trig(input logic [31:0] ctl, output int n);
    wr(3'd0, ctl);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      step(1);
      if (trig_o) n++;
    end
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    int n;
    count_trig(RUN | OE | (32'h1 << 4), n);
    chk("R12 no pulse when trigger disabled", n, 0);
    wr(3'd6, 32'h8);
    step(4);
    rd(3'd6, v); chk("R13 trigger flag stays clear", v & 32'h8, 0);
    count_trig(RUN | OE | TEN | (32'h1 << 4), n);
    chk("R12 period source pulses", n, 4);
    rd(3'd6, v); chk("R13 trigger flag set", v & 32'h8, 32'h8);
    count_trig(RUN | OE | TEN | (32'h3 << 4), n);
    chk("R12 compare source pulses", n, 4);
    count_trig(RUN | OE | TEN | (32'h5 << 4), n);
    chk("R12 either source pulses", n, 8);
    count_trig(RUN | OE | TEN | (32'h0 << 4), n);
    chk("R12 unused code gives no pulse", n, 0);
    wr(3'd6, 32'h8);
    rd(3'd6, v); chk("R13 trigger flag w1c", v & 32'h8, 0);
  endtask

  task automatic t_irq();
    wr(3'd0, RUN | OE);
    wr(3'd6, 32'hF);
    step(8);
    chk("R14 irq masked", irq_o, 0);
    wr(3'd0, RUN | OE | IEP);
    chk("R14 irq on enabled period flag", irq_o, 1);
    wr(3'd0, OE | IEP);
    wr(3'd6, 32'hF);
    chk("R14 irq drops after flag clear", irq_o, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(3'd7, 1);
    wr(3'd0, RUN | OE | (32'd2 << 16));
    step(2); rd(3'd5, v); chk("R1 no tick before third clock", v, 0);
    step(1); rd(3'd5, v); chk("R1 first divided tick", v, 1);
    step(2); rd(3'd5, v); chk("R1 held between ticks", v, 1);
    step(1); rd(3'd5, v); chk("R1 second divided tick", v, 2);
  endtask

  task automatic t_outputs();
    wr(3'd0, OE);
    wr(3'd7, 1);
    chk("R9 pwm high at count 0", pwm_o, 1);
    wr(3'd0, OE | INV);
    chk("R9 inverted output", pwm_o, 0);
    wr(3'd0, INV);
    chk("R10 pad disabled", pwm_oe, 0);
    chk("R10 output held low", pwm_o, 0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(3'd0, RUN | OE);
    step(2);
    wr(3'd7, 1);
    rd(3'd5, v); chk("R8 counter cleared", v, 0);
    rd(3'd7, v); chk("R8 clear word reads 0", v, 0);
    step(1);
    rd(3'd5, v); chk("R8 counting resumes", v, 1);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(3'd0, OE);
    wr(3'd7, 1);
    wr(3'd6, 32'hF);
    wr(3'd0, RUN | OE | ONE);
    step(3); rd(3'd5, v); chk("R6 reached period", v, 3);
    step(1);
    rd(3'd0, v); chk("R6 run bit self-cleared", v & RUN, 0);
    rd(3'd6, v); chk("R4 period flag in one-shot", v & 32'h1, 1);
    step(4);
    rd(3'd5, v); chk("R6 counter stays on period", v, 3);
  endtask

  task automatic t_max();
    logic [31:0] v;
    wr(3'd0, OE);
    wr(3'd1, 32'hFFFF);
    wr(3'd7, 1);
    wr(3'd6, 32'hF);
    wr(3'd0, RUN | OE);
    step(8);
    rd(3'd3, v); chk("R3 full-range period loaded", v, 32'hFFFF);
    rd(3'd6, v); chk("R11 max flag clear early", v & 32'h4, 0);
    step(70000);
    rd(3'd6, v); chk("R11 max flag set", v & 32'h4, 32'h4);
    wr(3'd0, OE);
    wr(3'd6, 32'h4);
    rd(3'd6, v); chk("R11 max flag w1c", v & 32'h4, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_shadow();
    t_count();
    t_flags();
    t_suppress();
    t_trigger();
    t_irq();
    t_prescale();
    t_outputs();
    t_clear();
    t_oneshot();
    t_max();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule